// File: doc/BRIEF.md
# Four-Channel DMA Command Decoder and Service Arbiter

This block is the control half of a four-channel DMA controller. It takes byte-wide register writes and reads from a host port. Each write offset selects one control action: command, software request, single mask, mode, flip-flop clear, master reset, clear-all-masks or load-all-masks. The block keeps the per-channel mask bits, a shared status byte and a mode byte for each channel.

External logic reports requests through hold and release pulses, and terminal-count pulses for each channel. The block combines these with the software requests into one request bit per channel. Every cycle it grants service to the lowest-numbered channel that is both requesting and unmasked, unless the controller is disabled.

The address and count registers, the page registers and the data mover sit outside this unit. Those neighbours consume three outputs: the mode bytes, the direction flags and a strobe that tells them to reset their byte-pointer flip-flop.

Top module: `dmac_ctl_arbiter`

## Requirements
- R1: After an asynchronous reset the block behaves as after a master reset: mask is 4'hF, status and command are 0. In addition, every mode byte is 0, the grant is 0 and the flip-flop strobe is low.
- R2: With `rd_en` high, `rdata` is combinational. Offset 8 returns the status byte: bits [7:4] are the request bits of channels 3..0, and bits [3:0] are the terminal-count bits of channels 3..0. Offset 0xF returns {4'h0, mask}. Every other offset, and any cycle with `rd_en` low, returns 0.
- R3: A write to offset 1 is stored as the command only when the data is zero or sets no bit other than bit 2. Any other value leaves the command unchanged. While command bit 2 is 1, no grant is issued.
- R4: A write to offset 2 takes its channel from data[1:0]. It sets that channel's request bit when data[2] is 1 and clears it when data[2] is 0. In both cases it clears that channel's terminal-count bit.
- R5: A write to offset 3 sets mask bit data[1:0] when data[2] is 1 and clears it otherwise. A write to offset 7 clears all mask bits. A write to offset 8 loads the mask from data[3:0].
- R6: A write to offset 4 stores the whole data byte as the mode of channel data[1:0]. `mode_out[8*c+7:8*c]` carries channel c's mode, and `dir_down[c]` equals bit 5 of that mode.
- R7: A write to offset 5 or offset 6 raises `ff_clear` for exactly the one cycle after the write edge.
- R8: A write to offset 6 sets all mask bits to 1 and clears status and command. Mode bytes are kept.
- R9: A status read, meaning `rd_en` high at offset 8, clears bits [3:0] at that clock edge and keeps bits [7:4]. A `tc_done[c]` pulse sets terminal-count bit c and wins over a clear in the same cycle.
- R10: A `dreq_hold[c]` pulse sets request bit c and a `dreq_release[c]` pulse clears it. Both are applied after any register write in the same cycle, and hold wins over release.
- R11: `grant` is registered and at most one-hot. It names the lowest-numbered channel whose mask bit is 0 and whose request bit is 1, as those bits stood at the previous clock edge.
- R12: Writes to offsets 0 and 9 to 0xF change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| tc_done | input | 4 | Terminal-count pulses per channel |
| dreq_hold | input | 4 | External request hold pulses per channel |
| dreq_release | input | 4 | External request release pulses per channel |
| mode_out | output | 32 | Mode byte of each channel, channel 0 in bits [7:0] |
| dir_down | output | 4 | Address-decrement flag per channel |
| ff_clear | output | 1 | One-cycle strobe to clear the byte flip-flop |
| grant | output | 4 | One-hot service grant |

## Verification
Several patterns drive the arbitration. Some channels request while masked and others are unmasked while idle, which separates the request term from the mask term. Two channels are eligible at once, which exposes the priority order. Channels are also enabled with the controller disabled, and then with an unsupported command that must not re-enable it. Further patterns apply a software write and an external hold in the same cycle, or a hold and a release together, which pins the order of precedence. A terminal-count pulse in the same cycle as a status read shows that the set wins over the destructive clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned OFS_W = 4;

  localparam logic [OFS_W-1:0] OFS_CMD     = 4'h1;
  localparam logic [OFS_W-1:0] OFS_REQ     = 4'h2;
  localparam logic [OFS_W-1:0] OFS_SMASK   = 4'h3;
  localparam logic [OFS_W-1:0] OFS_MODE    = 4'h4;
  localparam logic [OFS_W-1:0] OFS_FFCLR   = 4'h5;
  localparam logic [OFS_W-1:0] OFS_MRESET  = 4'h6;
  localparam logic [OFS_W-1:0] OFS_CLRMASK = 4'h7;
  localparam logic [OFS_W-1:0] OFS_WRMASK  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_STATUS  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_MASKRD  = 4'hF;

  localparam int unsigned SET_BIT     = 2;
  localparam int unsigned DISABLE_BIT = 2;
  localparam int unsigned DIR_BIT     = 5;

  typedef struct packed {
    logic cmd_wr;
    logic req_wr;
    logic smask_wr;
    logic mode_wr;
    logic ffclr_wr;
    logic mreset_wr;
    logic clrmask_wr;
    logic wrmask_wr;
    logic stat_rd;
  } dmac_op_t;
endpackage

// File: rtl/dmac_cmd_decode.sv
module dmac_cmd_decode
  import dmac_pkg::*;
(
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [OFS_W-1:0] addr,
  output dmac_op_t         op
);
  always_comb begin
    op = '0;
    if (wr_en) begin
      unique case (addr)
        OFS_CMD:     op.cmd_wr     = 1'b1;
        OFS_REQ:     op.req_wr     = 1'b1;
        OFS_SMASK:   op.smask_wr   = 1'b1;
        OFS_MODE:    op.mode_wr    = 1'b1;
        OFS_FFCLR:   op.ffclr_wr   = 1'b1;
        OFS_MRESET:  op.mreset_wr  = 1'b1;
        OFS_CLRMASK: op.clrmask_wr = 1'b1;
        OFS_WRMASK:  op.wrmask_wr  = 1'b1;
        default:     ;
      endcase
    end
    if (rd_en && (addr == OFS_STATUS)) begin
      op.stat_rd = 1'b1;
    end
  end
endmodule

// File: rtl/dmac_state_regs.sv
module dmac_state_regs
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  dmac_op_t                     op,
  input  logic [DW-1:0]                wdata,
  input  logic [NUM_CH-1:0]            tc_done,
  input  logic [NUM_CH-1:0]            dreq_hold,
  input  logic [NUM_CH-1:0]            dreq_release,
  output logic [NUM_CH-1:0]            mask_q,
  output logic [2*NUM_CH-1:0]          status_q,
  output logic [DW-1:0]                cmd_q,
  output logic [NUM_CH-1:0][DW-1:0]    mode_q,
  output logic                         ff_clear_q
);
  localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [DW-1:0] CMD_ALLOWED = DW'(1) << DISABLE_BIT;

  logic [NUM_CH-1:0]         mask_d;
  logic [2*NUM_CH-1:0]       status_d;
  logic [DW-1:0]             cmd_d;
  logic [NUM_CH-1:0][DW-1:0] mode_d;
  logic                      ff_clear_d;
  logic                      upd_en;
  logic [CH_W-1:0]           ch;
  logic                      cmd_ok;

  always_comb begin
    ch         = wdata[CH_W-1:0];
    cmd_ok     = (wdata == '0) || ((wdata & ~CMD_ALLOWED) == '0);
    mask_d     = mask_q;
    status_d   = status_q;
    cmd_d      = cmd_q;
    mode_d     = mode_q;
    ff_clear_d = 1'b0;

    if (op.stat_rd) begin
      status_d[NUM_CH-1:0] = '0;
    end
    if (op.cmd_wr && cmd_ok) begin
      cmd_d = wdata;
    end
    if (op.req_wr) begin
      status_d[NUM_CH + 32'(ch)] = wdata[SET_BIT];
      status_d[ch]               = 1'b0;
    end
    if (op.smask_wr) begin
      mask_d[ch] = wdata[SET_BIT];
    end
    if (op.mode_wr) begin
      mode_d[ch] = wdata;
    end
    if (op.ffclr_wr) begin
      ff_clear_d = 1'b1;
    end
    if (op.mreset_wr) begin
      ff_clear_d = 1'b1;
      mask_d     = '1;
      status_d   = '0;
      cmd_d      = '0;
    end
    if (op.clrmask_wr) begin
      mask_d = '0;
    end
    if (op.wrmask_wr) begin
      mask_d = wdata[NUM_CH-1:0];
    end

    status_d[NUM_CH-1:0] = status_d[NUM_CH-1:0] | tc_done;
    for (int c = 0; c < NUM_CH; c++) begin
      if (dreq_release[c]) status_d[NUM_CH+c] = 1'b0;
      if (dreq_hold[c])    status_d[NUM_CH+c] = 1'b1;
    end

    upd_en = (|op) || (|tc_done) || (|dreq_hold) || (|dreq_release) || ff_clear_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '1;
      status_q   <= '0;
      cmd_q      <= '0;
      mode_q     <= '0;
      ff_clear_q <= 1'b0;
    end else if (upd_en) begin
      mask_q     <= mask_d;
      status_q   <= status_d;
      cmd_q      <= cmd_d;
      mode_q     <= mode_d;
      ff_clear_q <= ff_clear_d;
    end
  end
endmodule

// File: rtl/dmac_grant_pick.sv
module dmac_grant_pick #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_disable,
  input  logic [NUM_CH-1:0] mask,
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] grant_q
);
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] pick;

  always_comb begin
    elig = req & ~mask & {NUM_CH{~ctl_disable}};
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
    end else begin
      grant_q <= pick;
    end
  end
endmodule

// File: rtl/dmac_ctl_arbiter.sv
module dmac_ctl_arbiter
  import dmac_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [3:0]           addr,
  input  logic [DW-1:0]        wdata,
  output logic [DW-1:0]        rdata,
  input  logic [NUM_CH-1:0]    tc_done,
  input  logic [NUM_CH-1:0]    dreq_hold,
  input  logic [NUM_CH-1:0]    dreq_release,
  output logic [NUM_CH*DW-1:0] mode_out,
  output logic [NUM_CH-1:0]    dir_down,
  output logic                 ff_clear,
  output logic [NUM_CH-1:0]    grant
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]    rst_pipe;
  logic                      rst_sync_n;
  dmac_op_t                  op;
  logic [NUM_CH-1:0]         mask_w;
  logic [2*NUM_CH-1:0]       status_w;
  logic [DW-1:0]             cmd_w;
  logic [NUM_CH-1:0][DW-1:0] mode_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  dmac_cmd_decode u_decode (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .op    (op)
  );

  dmac_state_regs #(.NUM_CH(NUM_CH), .DW(DW)) u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .op           (op),
    .wdata        (wdata),
    .tc_done      (tc_done),
    .dreq_hold    (dreq_hold),
    .dreq_release (dreq_release),
    .mask_q       (mask_w),
    .status_q     (status_w),
    .cmd_q        (cmd_w),
    .mode_q       (mode_w),
    .ff_clear_q   (ff_clear)
  );

  dmac_grant_pick #(.NUM_CH(NUM_CH)) u_pick (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .ctl_disable (cmd_w[DISABLE_BIT]),
    .mask        (mask_w),
    .req         (status_w[2*NUM_CH-1:NUM_CH]),
    .grant_q     (grant)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == OFS_STATUS) begin
        rdata = DW'(status_w);
      end else if (addr == OFS_MASKRD) begin
        rdata = DW'(mask_w);
      end
    end
  end

  assign mode_out = mode_w;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dir
    assign dir_down[g] = mode_w[g][DIR_BIT];
  end
endmodule

// File: rtl/dmac_ctl_arbiter_chk.sv
module dmac_ctl_arbiter_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DW     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [3:0]           addr,
  input logic [DW-1:0]        wdata,
  input logic [NUM_CH-1:0]    tc_done,
  input logic [NUM_CH-1:0]    dreq_hold,
  input logic [NUM_CH-1:0]    dreq_release,
  input logic [NUM_CH-1:0]    mask,
  input logic [2*NUM_CH-1:0]  status,
  input logic [DW-1:0]        cmd,
  input logic                 ff_clear,
  input logic [NUM_CH-1:0]    grant
);
  a_r11_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    $onehot0(grant));

  a_r11_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (|grant) |-> (((grant & $past(mask)) == '0) &&
                  ((grant & ~$past(status[2*NUM_CH-1:NUM_CH])) == '0)));

  a_r3_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    cmd[2] |=> (grant == '0));

  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (wr_en && addr == 4'h1 && wdata != '0 && (wdata & ~DW'(4)) != '0) |=> $stable(cmd));

  a_r8_master_reset: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (wr_en && addr == 4'h6 && tc_done == '0 && dreq_hold == '0)
      |=> (mask == '1 && status == '0 && cmd == '0));

  a_r7_ff_strobe: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (wr_en && (addr == 4'h5 || addr == 4'h6)) |=> ff_clear);

  a_r9_read_clears_tc: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (rd_en && addr == 4'h8 && tc_done == '0) |=> (status[NUM_CH-1:0] == '0));

  a_r10_hold_sets: assert property (@(posedge clk) disable iff (!rst_n || !rst_sync_n)
    (|dreq_hold) |=> ((status[2*NUM_CH-1:NUM_CH] & $past(dreq_hold)) == $past(dreq_hold)));
endmodule

bind dmac_ctl_arbiter dmac_ctl_arbiter_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_sync_n   (rst_sync_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .tc_done      (tc_done),
  .dreq_hold    (dreq_hold),
  .dreq_release (dreq_release),
  .mask         (mask_w),
  .status       (status_w),
  .cmd          (cmd_w),
  .ff_clear     (ff_clear),
  .grant        (grant)
);

// File: tb/dmac_ctl_arbiter_tb.sv
module dmac_ctl_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {is_read, offset, data, expected rdata, expected grant}
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 4'hF, 8'h00, 8'h0F, 4'h0},  // R2 mask after reset
    {1'b0, 4'h2, 8'h05, 8'h00, 4'h0},  // R4 request ch1, masked
    {1'b1, 4'h8, 8'h00, 8'h20, 4'h0},  // R2 status
    {1'b0, 4'h3, 8'h01, 8'h00, 4'h2},  // R5 unmask ch1
    {1'b1, 4'hF, 8'h00, 8'h0D, 4'h2},  // R5 mask readback
    {1'b0, 4'h2, 8'h07, 8'h00, 4'h2},  // R4 request ch3, still masked
    {1'b0, 4'h8, 8'h00, 8'h00, 4'h2},  // R5 load all masks, ch1 wins
    {1'b0, 4'h2, 8'h01, 8'h00, 4'h8},  // R4 drop ch1 request
    {1'b0, 4'h1, 8'h04, 8'h00, 4'h0},  // R3 disable
    {1'b0, 4'h1, 8'h10, 8'h00, 4'h0},  // R3 rejected command
    {1'b0, 4'h1, 8'h00, 8'h00, 4'h8},  // R3 enable
    {1'b0, 4'h3, 8'h07, 8'h00, 4'h0},  // R5 mask ch3
    {1'b0, 4'h7, 8'h00, 8'h00, 4'h8},  // R5 clear all masks
    {1'b1, 4'h3, 8'h00, 8'h00, 4'h8},  // R2 other offset reads 0
    {1'b1, 4'h8, 8'h00, 8'h80, 4'h8},  // R2 status
    {1'b0, 4'h6, 8'h00, 8'h00, 4'h0},  // R8 master reset
    {1'b1, 4'hF, 8'h00, 8'h0F, 4'h0},  // R8 mask all ones
    {1'b1, 4'h8, 8'h00, 8'h00, 4'h0}   // R8 status zero
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [3:0]  addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic [3:0]  tc_done, dreq_hold, dreq_release;
  logic [31:0] mode_out;
  logic [3:0]  dir_down;
  logic        ff_clear;
  logic [3:0]  grant;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0] seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmac_ctl_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tc_done(tc_done), .dreq_hold(dreq_hold),
    .dreq_release(dreq_release), .mode_out(mode_out), .dir_down(dir_down),
    .ff_clear(ff_clear), .grant(grant)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns two falling edges later.
  task automatic access(input bit rd, input logic [3:0] a, input logic [7:0] d,
                        output logic [7:0] rd_val);
    wr_en = !rd; rd_en = rd; addr = a; wdata = d;
    #1 rd_val = rdata;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; addr = 4'h0; wdata = 8'h00;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    tc_done = 0; dreq_hold = 0; dreq_release = 0;
    do_reset();

    // R1 reset state
    check("R1 grant", grant, 0);
    check("R1 ff_clear", ff_clear, 0);
    check("R1 mode_out", mode_out, 0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][24], VEC[i][23:20], VEC[i][19:12], seen);
      if (VEC[i][24]) check($sformatf("R2 read vec %0d", i), seen, VEC[i][11:4]);
      check($sformatf("R11 grant vec %0d", i), grant, VEC[i][3:0]);
    end

    // R6 mode writes and direction flag
    access(0, 4'h4, 8'h26, seen);
    check("R6 mode ch2", mode_out, 32'h0026_0000);
    check("R6 dir_down", dir_down, 4'b0100);
    access(0, 4'h4, 8'h01, seen);
    check("R6 mode ch1", mode_out, 32'h0026_0100);
    check("R6 dir_down keep", dir_down, 4'b0100);

    // R7 flip-flop clear strobe
    wr_en = 1; addr = 4'h5;
    @(negedge clk); wr_en = 0; addr = 0;
    check("R7 strobe high", ff_clear, 1);
    @(negedge clk);
    check("R7 strobe low", ff_clear, 0);

    // R9 terminal count and destructive read
    tc_done = 4'b0101;
    @(negedge clk); tc_done = 0;
    access(1, 4'h8, 0, seen);
    check("R9 tc read", seen, 8'h05);
    access(1, 4'h8, 0, seen);
    check("R9 tc cleared", seen, 8'h00);
    tc_done = 4'b0010;
    access(1, 4'h8, 0, seen);
    tc_done = 0;
    check("R9 same-cycle read", seen, 8'h00);
    access(1, 4'h8, 0, seen);
    check("R9 tc set wins", seen, 8'h02);
    tc_done = 4'b0010;
    @(negedge clk); tc_done = 0;
    access(0, 4'h2, 8'h01, seen);
    access(1, 4'h8, 0, seen);
    check("R4 request write clears tc", seen, 8'h00);

    // R10 external hold/release
    access(0, 4'h7, 0, seen);
    dreq_hold = 4'b0100;
    @(negedge clk); dreq_hold = 0;
    @(negedge clk);
    check("R10 hold grant", grant, 4'b0100);
    dreq_hold = 4'b0001; dreq_release = 4'b0001;
    @(negedge clk); dreq_hold = 0; dreq_release = 0;
    @(negedge clk);
    check("R10 hold beats release", grant, 4'b0001);
    dreq_release = 4'b0101;
    @(negedge clk); dreq_release = 0;
    @(negedge clk);
    check("R10 release", grant, 4'b0000);
    dreq_hold = 4'b1000;
    access(0, 4'h2, 8'h03, seen);
    dreq_hold = 0;
    access(1, 4'h8, 0, seen);
    check("R10 hold after write", seen, 8'h80);

    // R12 ignored offsets
    access(0, 4'h0, 8'hFF, seen);
    access(0, 4'h9, 8'hFF, seen);
    access(0, 4'hF, 8'hFF, seen);
    access(1, 4'hF, 0, seen);
    check("R12 mask kept", seen, 8'h00);
    access(1, 4'h8, 0, seen);
    check("R12 status kept", seen, 8'h80);
    check("R12 grant kept", grant, 4'b1000);

    // R1 reset in the middle of operation
    do_reset();
    check("R1 grant after reset", grant, 0);
    check("R1 modes after reset", mode_out, 0);
    access(1, 4'hF, 0, seen);
    check("R1 mask after reset", seen, 8'h0F);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule